// File: doc/BRIEF.md
# Program Counter Sequencer with Interrupt Entry

This block owns the instruction address of a small core and decides, once per completed instruction, where execution goes next. It holds the program counter, a bounded hardware stack of return addresses for subroutine calls, the interrupt-enable bit, and the saved program counter and Z/C flags used while an interrupt is being serviced. The decoder hands it one command per instruction together with a signed displacement, an absolute target and the current flags. A fetch-advance strobe marks the cycle in which that instruction completes.

Relative branches are measured from the address that follows the branch, so a zero displacement falls through to the next instruction. Interrupts are recognised only at instruction boundaries. Entry saves the address the interrupted instruction would have continued at, together with the flags, clears the enable bit, vectors to a fixed address and pulses an acknowledge. A wait command parks the sequencer until an enabled interrupt arrives. A return-from-interrupt command gives back the saved address and presents the saved flags on a one-cycle restore strobe for the flag register to reload.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-low reset sets the PC to 0 and clears int_ack, stalled and flags_restore. It also clears the interrupt-enable bit, so a raised int_req is ignored after reset.
- R2: A command is acted on only in a cycle with advance high; with advance low the PC holds. Command code 0 (sequential), and the unused codes 9 to 15, load PC+1 modulo 4096.
- R3: Command code 1 is a conditional branch. cond_sel 00 tests Z set, 01 tests Z clear, 10 tests C set and 11 tests C clear. When taken, the PC becomes PC+1 plus the sign-extended 8-bit disp, modulo 4096; otherwise it becomes PC+1.
- R4: Command code 2 loads the PC with the 12-bit target.
- R5: Command code 3 pushes PC+1 onto the return stack and loads target; command code 4 pops the top entry into the PC. Nesting to a depth of 8 returns the addresses in last-in first-out order.
- R6: At an advance with int_req high and the enable bit set after that instruction's own effect on it, the block saves the address that instruction would have gone to and the flag_z/flag_c inputs. It then clears the enable bit and loads PC 1. int_ack is high in exactly the one cycle in which PC first shows 1.
- R7: Command code 5 loads the saved address, sets the enable bit, and pulses flags_restore for one cycle with z_restore/c_restore equal to the flags saved at entry.
- R8: Command code 6 sets and command code 7 clears the enable bit, each taking effect for an interrupt at the same boundary; with the bit clear, int_req has no effect.
- R9: Command code 8 loads PC+1 and raises stalled. The PC and stalled then hold, with advance ignored, until int_req arrives with the enable bit set. Entry then saves the address after the wait and drops stalled.
- R10: While advance is low outside a wait, a raised int_req is not taken, even with the enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| advance | input | 1 | Current instruction completes this cycle |
| cmd | input | 4 | Control-flow command code |
| cond_sel | input | 2 | Branch condition select |
| disp | input | 8 | Signed branch displacement |
| target | input | 12 | Absolute jump or call address |
| flag_z | input | 1 | Current zero flag |
| flag_c | input | 1 | Current carry flag |
| int_req | input | 1 | Interrupt request |
| pc | output | 12 | Program counter |
| int_ack | output | 1 | One-cycle interrupt acknowledge |
| stalled | output | 1 | Sequencer parked by a wait command |
| flags_restore | output | 1 | One-cycle strobe to reload the flags |
| z_restore | output | 1 | Zero flag value to reload |
| c_restore | output | 1 | Carry flag value to reload |

## Verification
The bench builds the block with its default parameters: a 12-bit PC, an 8-bit displacement, a return stack 8 deep and interrupt vector 1. With these values every condition code can be swept against every Z/C combination and a spread of displacements from -128 to +127. Address wraparound at 4095 can be reached directly. The stack can be filled to its full depth and drained in order. Interrupt entry is driven from a plain instruction, from a taken branch, from an enabling command at the same boundary and from a parked wait, and each entry is followed by a return that reproduces the saved address and flags.

// File: rtl/pcseq_pkg.sv
// Shared command encoding for the program counter sequencer.
// Assumes the decoder drives one of these codes per completed instruction.
package pcseq_pkg;
    typedef enum logic [3:0] {
        OP_SEQ    = 4'd0,
        OP_BRANCH = 4'd1,
        OP_JUMP   = 4'd2,
        OP_CALL   = 4'd3,
        OP_RETURN = 4'd4,
        OP_IRET   = 4'd5,
        OP_IEN    = 4'd6,
        OP_IDIS   = 4'd7,
        OP_WAIT   = 4'd8
    } seq_op_e;
endpackage

// File: rtl/seq_ret_stack.sv
// Bounded return-address stack.
// Assumes push and pop are never requested together. A push when full
// overwrites the top entry; reading an empty stack yields zero.
module seq_ret_stack #(
    parameter int AW    = 12,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    output logic [AW-1:0] top_addr
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] entries [DEPTH];
    logic [CW-1:0] count;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;

    // Write slot: next free entry, or the top one when full.
    always_comb begin
        wr_idx = (count == CW'(DEPTH)) ? IW'(DEPTH - 1) : count[IW-1:0];
        rd_idx = IW'(count - CW'(1));
    end

    // Top-of-stack read, zero when empty.
    always_comb begin
        top_addr = (count == '0) ? '0 : entries[rd_idx];
    end

    // Entry storage and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) entries[i] <= '0;
        end else if (push) begin
            entries[wr_idx] <= push_addr;
            if (count != CW'(DEPTH)) count <= count + CW'(1);
        end else if (pop) begin
            if (count != '0) count <= count - CW'(1);
        end
    end

    AST_PUSH_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (top_addr == $past(push_addr))); // R5
endmodule

// File: rtl/seq_next_pc.sv
// Combinational next-address selection for one completed instruction.
// Assumes AW > DW; the branch displacement is relative to PC+1.
module seq_next_pc
    import pcseq_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic [AW-1:0] pc,
    input  seq_op_e       op,
    input  logic [1:0]    cond_sel,
    input  logic [DW-1:0] disp,
    input  logic [AW-1:0] target,
    input  logic          flag_z,
    input  logic          flag_c,
    input  logic [AW-1:0] stack_top,
    input  logic [AW-1:0] saved_pc,
    output logic [AW-1:0] pc_inc,
    output logic [AW-1:0] next_pc
);
    localparam int EXT = AW - DW;

    logic          cond_true;
    logic [AW-1:0] disp_ext;

    // Condition evaluation and displacement sign extension.
    always_comb begin
        unique case (cond_sel)
            2'b00:   cond_true = flag_z;
            2'b01:   cond_true = !flag_z;
            2'b10:   cond_true = flag_c;
            default: cond_true = !flag_c;
        endcase
        disp_ext = {{EXT{disp[DW-1]}}, disp};
        pc_inc   = pc + AW'(1);
    end

    // Next address by command.
    always_comb begin
        case (op)
            OP_BRANCH: next_pc = cond_true ? (pc_inc + disp_ext) : pc_inc;
            OP_JUMP,
            OP_CALL:   next_pc = target;
            OP_RETURN: next_pc = stack_top;
            OP_IRET:   next_pc = saved_pc;
            default:   next_pc = pc_inc;
        endcase
    end
endmodule

// File: rtl/seq_irq_ctrl.sv
// Interrupt enable, entry decision, wait parking and shadow state.
// Assumes int_req is level-sensitive; entry happens only at an advance
// or while parked by a wait command.
module seq_irq_ctrl
    import pcseq_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  seq_op_e       op,
    input  logic          int_req,
    input  logic          flag_z,
    input  logic          flag_c,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] next_pc,
    output logic          ie,
    output logic          parked,
    output logic          take,
    output logic [AW-1:0] saved_pc,
    output logic          int_ack,
    output logic          restore,
    output logic          z_out,
    output logic          c_out
);
    logic exec;
    logic ie_after;
    logic saved_z;
    logic saved_c;

    // Enable value after this instruction, and the entry decision.
    always_comb begin
        exec = advance && !parked;
        ie_after = ie;
        if (exec && (op == OP_IEN || op == OP_IRET)) ie_after = 1'b1;
        if (exec && op == OP_IDIS)                   ie_after = 1'b0;
        take = int_req && (parked ? ie : (advance && ie_after));
    end

    // Enable bit, wait parking and acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie      <= 1'b0;
            parked  <= 1'b0;
            int_ack <= 1'b0;
        end else begin
            int_ack <= take;
            if (take) begin
                ie     <= 1'b0;
                parked <= 1'b0;
            end else begin
                ie <= ie_after;
                if (exec && op == OP_WAIT) parked <= 1'b1;
            end
        end
    end

    // Shadow copies saved at entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_pc <= '0;
            saved_z  <= 1'b0;
            saved_c  <= 1'b0;
        end else if (take) begin
            saved_pc <= parked ? pc : next_pc;
            saved_z  <= flag_z;
            saved_c  <= flag_c;
        end
    end

    // Flag restore strobe and values on return from interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restore <= 1'b0;
            z_out   <= 1'b0;
            c_out   <= 1'b0;
        end else begin
            restore <= exec && op == OP_IRET;
            if (exec && op == OP_IRET) begin
                z_out <= saved_z;
                c_out <= saved_c;
            end
        end
    end

    AST_ACK_IE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> !ie); // R6
    AST_ACK_UNPARKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> !parked); // R9
endmodule

// File: rtl/pc_sequencer.sv
// Program counter sequencer: holds the PC and applies one control-flow
// command per advance, with return stack and interrupt entry/exit.
// Assumes cmd, cond_sel, disp, target and flags are valid when advance is high.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 8,
    parameter int DEPTH     = 8,
    parameter int VECTOR    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic [3:0]    cmd,
    input  logic [1:0]    cond_sel,
    input  logic [DW-1:0] disp,
    input  logic [AW-1:0] target,
    input  logic          flag_z,
    input  logic          flag_c,
    input  logic          int_req,
    output logic [AW-1:0] pc,
    output logic          int_ack,
    output logic          stalled,
    output logic          flags_restore,
    output logic          z_restore,
    output logic          c_restore
);
    localparam logic [AW-1:0] VEC_ADDR = AW'(VECTOR);

    seq_op_e       op;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] pc_inc;
    logic [AW-1:0] next_pc;
    logic [AW-1:0] stack_top;
    logic [AW-1:0] saved_pc;
    logic          ie;
    logic          parked;
    logic          take;
    logic          exec;
    logic          push;
    logic          pop;

    // Command decode into stack controls.
    always_comb begin
        op   = seq_op_e'(cmd);
        exec = advance && !parked;
        push = exec && op == OP_CALL;
        pop  = exec && op == OP_RETURN;
    end

    seq_next_pc #(.AW(AW), .DW(DW)) u_next (
        .pc(pc_q), .op(op), .cond_sel(cond_sel), .disp(disp),
        .target(target), .flag_z(flag_z), .flag_c(flag_c),
        .stack_top(stack_top), .saved_pc(saved_pc),
        .pc_inc(pc_inc), .next_pc(next_pc)
    );

    seq_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_addr(pc_inc), .top_addr(stack_top)
    );

    seq_irq_ctrl #(.AW(AW)) u_irq (
        .clk(clk), .rst_n(rst_n), .advance(advance), .op(op),
        .int_req(int_req), .flag_z(flag_z), .flag_c(flag_c),
        .pc(pc_q), .next_pc(next_pc), .ie(ie), .parked(parked),
        .take(take), .saved_pc(saved_pc), .int_ack(int_ack),
        .restore(flags_restore), .z_out(z_restore), .c_out(c_restore)
    );

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)    pc_q <= '0;
        else if (take) pc_q <= VEC_ADDR;
        else if (exec) pc_q <= next_pc;
    end

    assign pc      = pc_q;
    assign stalled = parked;

    AST_ACK_AT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> (pc_q == VEC_ADDR)); // R6
    AST_WAIT_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (parked && !int_req) |=> $stable(pc_q)); // R9
    AST_IDLE_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !parked && !int_req) |=> $stable(pc_q)); // R2
endmodule

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        advance;
    logic [3:0]  cmd;
    logic [1:0]  cond_sel;
    logic [7:0]  disp;
    logic [11:0] target;
    logic        flag_z, flag_c, int_req;
    logic [11:0] pc;
    logic        int_ack, stalled, flags_restore, z_restore, c_restore;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pc_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .advance(advance), .cmd(cmd),
        .cond_sel(cond_sel), .disp(disp), .target(target),
        .flag_z(flag_z), .flag_c(flag_c), .int_req(int_req), .pc(pc),
        .int_ack(int_ack), .stalled(stalled), .flags_restore(flags_restore),
        .z_restore(z_restore), .c_restore(c_restore)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic [1:0] cs,
                        input logic [7:0] d, input logic [11:0] tg);
        cmd = op; cond_sel = cs; disp = d; target = tg; advance = 1'b1;
        @(posedge clk); #2;
        advance = 1'b0; cmd = 4'd0;
    endtask

    task automatic idle();
        @(posedge clk); #2;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] rets [8];
        logic [7:0]  dl [8];
        int base, exp_pc, cur;
        bit tk;
        dl[0] = 8'h00; dl[1] = 8'h01; dl[2] = 8'h7F; dl[3] = 8'h80;
        dl[4] = 8'hFF; dl[5] = 8'h55; dl[6] = 8'hAA; dl[7] = 8'h10;
        rst_n = 0; advance = 0; cmd = 0; cond_sel = 0; disp = 0; target = 0;
        flag_z = 0; flag_c = 0; int_req = 0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 pc", pc, 0);
        chk("R1 int_ack", int_ack, 0);
        chk("R1 stalled", stalled, 0);
        chk("R1 flags_restore", flags_restore, 0);
        rst_n = 1;
        // R1: enable bit clear after reset, request ignored
        int_req = 1;
        step(4'd0, 0, 0, 0);
        chk("R1 no entry pc", pc, 1);
        chk("R1 no entry ack", int_ack, 0);
        int_req = 0;
        // R2: advance low holds the PC
        cmd = 4'd2; target = 12'h123;
        idle(); idle(); idle();
        chk("R2 hold", pc, 1);
        cmd = 4'd0;
        // R4 and R2 wrap
        step(4'd2, 0, 0, 12'hFFF);
        chk("R4 jump", pc, 12'hFFF);
        step(4'd0, 0, 0, 0);
        chk("R2 wrap", pc, 0);
        step(4'd11, 0, 0, 0);
        chk("R2 unused code", pc, 1);
        // R3 sweep over condition, flags and displacement
        for (int cs = 0; cs < 4; cs++)
            for (int zc = 0; zc < 4; zc++)
                for (int k = 0; k < 8; k++) begin
                    base = 12'h7F0;
                    step(4'd2, 0, 0, base[11:0]);
                    flag_z = zc[1]; flag_c = zc[0];
                    tk = (cs == 0) ? zc[1] : (cs == 1) ? !zc[1] :
                         (cs == 2) ? zc[0] : !zc[0];
                    exp_pc = (base + 1 + (tk ? int'($signed(dl[k])) : 0)) & 12'hFFF;
                    step(4'd1, cs[1:0], dl[k], 0);
                    chk("R3 branch", pc, exp_pc);
                end
        flag_z = 1; flag_c = 0;
        step(4'd2, 0, 0, 12'hFFE);
        step(4'd1, 2'b00, 8'd5, 0);
        chk("R3 branch wrap", pc, 4);
        // R5 nested calls and returns
        step(4'd2, 0, 0, 12'h040);
        for (int i = 0; i < 8; i++) begin
            cur = pc;
            rets[i] = 12'(cur + 1);
            step(4'd3, 0, 0, 12'(12'h100 + i * 16));
            chk("R5 call target", pc, 12'h100 + i * 16);
        end
        for (int i = 7; i >= 0; i--) begin
            step(4'd4, 0, 0, 0);
            chk("R5 return order", pc, rets[i]);
        end
        // R6/R7 entry from a plain instruction and return
        step(4'd2, 0, 0, 12'h200);
        step(4'd6, 0, 0, 0);
        chk("R8 enable step", pc, 12'h201);
        flag_z = 1; flag_c = 0; int_req = 1;
        step(4'd0, 0, 0, 0);
        chk("R6 vector", pc, 1);
        chk("R6 ack", int_ack, 1);
        int_req = 0;
        idle();
        chk("R6 ack single", int_ack, 0);
        flag_z = 0; flag_c = 1;
        step(4'd2, 0, 0, 12'h300);
        step(4'd5, 0, 0, 0);
        chk("R7 return pc", pc, 12'h202);
        chk("R7 restore", flags_restore, 1);
        chk("R7 z", z_restore, 1);
        chk("R7 c", c_restore, 0);
        idle();
        chk("R7 restore single", flags_restore, 0);
        // R6 entry on a taken branch saves the branch target
        flag_z = 0; flag_c = 1; int_req = 1;
        step(4'd1, 2'b01, 8'd4, 0);
        chk("R6 branch entry", pc, 1);
        int_req = 0;
        step(4'd5, 0, 0, 0);
        chk("R7 branch return", pc, 12'h207);
        chk("R7 c saved", c_restore, 1);
        chk("R7 z saved", z_restore, 0);
        // R10 stalled fetch: no entry while advance low
        int_req = 1;
        idle(); idle(); idle();
        chk("R10 no entry pc", pc, 12'h207);
        chk("R10 no entry ack", int_ack, 0);
        // R8 disable at same boundary, then enable at same boundary
        step(4'd7, 0, 0, 0);
        chk("R8 disable blocks", pc, 12'h208);
        chk("R8 disable ack", int_ack, 0);
        step(4'd0, 0, 0, 0);
        chk("R8 disabled", pc, 12'h209);
        step(4'd6, 0, 0, 0);
        chk("R8 enable entry", pc, 1);
        chk("R8 enable ack", int_ack, 1);
        int_req = 0;
        step(4'd5, 0, 0, 0);
        chk("R8 return", pc, 12'h20A);
        // R9 wait parking
        step(4'd2, 0, 0, 12'h400);
        step(4'd8, 0, 0, 0);
        chk("R9 wait pc", pc, 12'h401);
        chk("R9 stalled", stalled, 1);
        step(4'd2, 0, 0, 12'h555);
        chk("R9 advance ignored", pc, 12'h401);
        idle(); idle();
        chk("R9 still stalled", stalled, 1);
        int_req = 1;
        idle();
        chk("R9 wake vector", pc, 1);
        chk("R9 wake ack", int_ack, 1);
        chk("R9 unstalled", stalled, 0);
        int_req = 0;
        step(4'd5, 0, 0, 0);
        chk("R9 return after wait", pc, 12'h402 - 1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule